// File: doc/BRIEF.md
# Table Entry Address Generator

This block turns an index (a device number, a collection number or similar) and the fields of one table descriptor into the byte address of the matching table entry. The table is either flat or two-level. A flat table places fixed-size entries back to back in a run of equally sized pages, so the address follows from a multiply and an add. A two-level table uses those pages to hold 64-bit pointers. The block first fetches the one pointer that covers the index through a memory read port, and then places the entry inside the page that pointer names.

Each lookup is accepted on a ready/valid request port. The block captures the index and the descriptor fields at that moment and works on that copy. Requests are rejected without any memory traffic when the table is not allocated or the index falls outside the space the descriptor describes. Only one lookup is in flight at a time. The answer leaves on a ready/valid response port with a two-bit status. Dividing the page size by a non-power-of-two entry size is done by a shared sequential divider.

Top module: `tbl_addr_gen`

## Requirements
- R1: For a flat table the response address is base + index*(entry_m1+1), with status OK (code 0). No memory read is issued.
- R2: The page code selects 4096 bytes (0), 16384 bytes (1), or 65536 bytes (2 and 3). The table spans (page_count+1) pages.
- R3: A flat lookup whose byte offset index*(entry_m1+1) is equal to or greater than the table span returns status RANGE (code 2) with address 0. An offset one entry below the span is accepted.
- R4: A two-level lookup issues exactly one read at base + 8*(index / E), where E = page bytes / (entry_m1+1), rounded down.
- R5: The read data is a little-endian 64-bit pointer: byte k sits in bits 8k+7..8k. The entry address is the pointer's low PA_W bits with the in-page offset bits cleared, plus (index mod E)*(entry_m1+1). The status is OK.
- R6: A pointer with bit 63 clear, or with any bit from PA_W to 62 set, returns status UNMAPPED (code 3) with address 0.
- R7: A two-level slot index equal to or greater than the span/8 returns RANGE with address 0, and no read is issued.
- R8: With cfg_valid low, every lookup returns status INVALID (code 1) with address 0, and no read is issued.
- R9: req_ready is high only when no lookup is in flight. It drops once a request is accepted and returns after the response is taken.
- R10: rsp_valid and the response fields hold steady until rsp_ready. rd_valid and rd_addr hold steady until rd_ready.
- R11: The index and every cfg_* input are sampled at request acceptance. Changes to them afterwards have no effect on that lookup.
- R12: During and right after reset, req_ready is 1 and both rd_valid and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_index | input | IDX_W | Index to translate |
| cfg_valid | input | 1 | Table memory is allocated |
| cfg_two_level | input | 1 | 1: two-level table, 0: flat |
| cfg_page_code | input | 2 | Page size code |
| cfg_page_count | input | 8 | Number of pages minus one |
| cfg_entry_m1 | input | 5 | Entry bytes minus one |
| cfg_base | input | PA_W | Table base byte address |
| rd_valid | output | 1 | Pointer read request valid |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | PA_W | Pointer byte address |
| rd_data_valid | input | 1 | Read data returned |
| rd_data | input | 64 | Returned pointer, little-endian |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_status | output | 2 | 0 OK, 1 INVALID, 2 RANGE, 3 UNMAPPED |
| rsp_addr | output | PA_W | Entry byte address, 0 unless OK |

## Verification
The bound checker watches the handshake rules on every cycle. These are the single lookup in flight, the response and read requests staying stable under back-pressure, and the zero address on every non-OK status. The arithmetic can only be shown by the bench's scenarios. That covers the page-size decode, flat offsets at and just below the span, the slot and remainder split across several entry sizes, the pointer decode and its fault cases, and the capture of inputs at acceptance. Those scenarios compare results against values derived by hand from the requirements.

// File: rtl/tbl_addr_pkg.sv
package tbl_addr_pkg;

    localparam int PGCODE_W = 2;
    localparam int PGCNT_W  = 8;
    localparam int ESZ_W    = 5;
    localparam int PB_W     = 17;              // up to 65536 bytes per page
    localparam int EB_W     = ESZ_W + 1;       // entry bytes 1..32
    localparam int TB_W     = PB_W + PGCNT_W;  // table span in bytes
    localparam int SLOTS_W  = TB_W - 3;        // 64-bit pointers per table

    typedef enum logic [1:0] {
        RSP_OK       = 2'd0,
        RSP_INVALID  = 2'd1,
        RSP_RANGE    = 2'd2,
        RSP_UNMAPPED = 2'd3
    } rsp_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_DIV_EPP,
        ST_DIV_SLOT,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_RESP
    } walk_state_e;

endpackage

// File: rtl/tbl_seqdiv.sv
module tbl_seqdiv #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     quo;
        logic [W-1:0]     rem;
        logic [W-1:0]     div;
    } div_state_t;

    div_state_t q, n;
    logic [W:0] trial;
    logic [W-1:0] quo_shift;

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        trial     = {q.rem, q.quo[W-1]};
        quo_shift = {q.quo[W-2:0], 1'b0};
        if (q.busy) begin
            if (trial >= {1'b0, q.div}) begin
                trial        = trial - {1'b0, q.div};
                quo_shift[0] = 1'b1;
            end
            n.quo = quo_shift;
            n.rem = trial[W-1:0];
            n.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(W - 1)) begin
                n.busy = 1'b0;
                n.done = 1'b1;
            end
        end else if (start_i) begin
            n.busy = 1'b1;
            n.cnt  = '0;
            n.quo  = dividend_i;
            n.rem  = '0;
            n.div  = divisor_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done_o = q.done;
    assign quot_o = q.quo;
    assign rem_o  = q.rem;

endmodule

// File: rtl/tbl_geom.sv
module tbl_geom
    import tbl_addr_pkg::*;
(
    input  logic [PGCODE_W-1:0] page_code_i,
    input  logic [PGCNT_W-1:0]  page_count_i,
    input  logic [ESZ_W-1:0]    entry_m1_i,
    output logic [PB_W-1:0]     page_bytes_o,
    output logic [EB_W-1:0]     entry_bytes_o,
    output logic [TB_W-1:0]     span_bytes_o,
    output logic [SLOTS_W-1:0]  slot_limit_o
);
    logic [4:0] shift;

    always_comb begin
        case (page_code_i)
            2'd0:    shift = 5'd12;
            2'd1:    shift = 5'd14;
            default: shift = 5'd16;  // code 3 behaves as code 2
        endcase
    end

    assign page_bytes_o  = PB_W'(1) << shift;
    assign entry_bytes_o = EB_W'(entry_m1_i) + EB_W'(1);
    assign span_bytes_o  = (TB_W'(page_count_i) + TB_W'(1)) << shift;
    assign slot_limit_o  = span_bytes_o[TB_W-1:3];

endmodule

// File: rtl/tbl_l1_desc.sv
module tbl_l1_desc
    import tbl_addr_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic [63:0]     desc_i,
    input  logic [PB_W-1:0] page_bytes_i,
    output logic            mapped_o,
    output logic [PA_W-1:0] page_base_o
);
    logic [PA_W-1:0] offset_mask;

    // Little-endian word: byte k of memory already occupies bits 8k+7..8k.
    assign offset_mask = PA_W'(page_bytes_i) - PA_W'(1);
    assign mapped_o    = desc_i[63] && (desc_i[62:PA_W] == '0);
    assign page_base_o = desc_i[PA_W-1:0] & ~offset_mask;

endmodule

// File: rtl/tbl_addr_gen.sv
module tbl_addr_gen
    import tbl_addr_pkg::*;
#(
    parameter int PA_W  = 48,
    parameter int IDX_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [IDX_W-1:0]    req_index,
    input  logic                cfg_valid,
    input  logic                cfg_two_level,
    input  logic [PGCODE_W-1:0] cfg_page_code,
    input  logic [PGCNT_W-1:0]  cfg_page_count,
    input  logic [ESZ_W-1:0]    cfg_entry_m1,
    input  logic [PA_W-1:0]     cfg_base,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [PA_W-1:0]     rd_addr,
    input  logic                rd_data_valid,
    input  logic [63:0]         rd_data,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [1:0]          rsp_status,
    output logic [PA_W-1:0]     rsp_addr
);
    localparam int DIV_W  = (IDX_W > PB_W) ? IDX_W : PB_W;
    localparam int OFF_W  = IDX_W + EB_W;
    localparam int ROFF_W = DIV_W + EB_W;
    localparam int CMP_A  = (OFF_W > TB_W) ? OFF_W : TB_W;
    localparam int CMP_W  = (CMP_A > DIV_W) ? CMP_A : DIV_W;

    typedef struct packed {
        walk_state_e         state;
        logic                tvalid;
        logic                two_level;
        logic [PGCODE_W-1:0] pcode;
        logic [PGCNT_W-1:0]  pcount;
        logic [ESZ_W-1:0]    esz_m1;
        logic [PA_W-1:0]     base;
        logic [IDX_W-1:0]    index;
        logic [DIV_W-1:0]    rem;
        logic [PA_W-1:0]     rd_addr;
        logic [PA_W-1:0]     rsp_addr;
        rsp_code_e           code;
    } walk_t;

    walk_t q, n;

    logic [PB_W-1:0]    page_bytes;
    logic [EB_W-1:0]    entry_bytes;
    logic [TB_W-1:0]    span_bytes;
    logic [SLOTS_W-1:0] slot_limit;

    logic               div_start;
    logic [DIV_W-1:0]   div_a, div_b;
    logic               div_done;
    logic [DIV_W-1:0]   div_quot, div_rem;

    logic               desc_mapped;
    logic [PA_W-1:0]    desc_page;

    logic [OFF_W-1:0]   flat_off;
    logic [ROFF_W-1:0]  page_off;
    logic               flat_over, slot_over;

    tbl_geom u_geom (
        .page_code_i   (q.pcode),
        .page_count_i  (q.pcount),
        .entry_m1_i    (q.esz_m1),
        .page_bytes_o  (page_bytes),
        .entry_bytes_o (entry_bytes),
        .span_bytes_o  (span_bytes),
        .slot_limit_o  (slot_limit)
    );

    tbl_seqdiv #(.W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_a),
        .divisor_i  (div_b),
        .done_o     (div_done),
        .quot_o     (div_quot),
        .rem_o      (div_rem)
    );

    tbl_l1_desc #(.PA_W(PA_W)) u_desc (
        .desc_i       (rd_data),
        .page_bytes_i (page_bytes),
        .mapped_o     (desc_mapped),
        .page_base_o  (desc_page)
    );

    assign flat_off  = OFF_W'(q.index) * OFF_W'(entry_bytes);
    assign page_off  = ROFF_W'(q.rem) * ROFF_W'(entry_bytes);
    assign flat_over = CMP_W'(flat_off) >= CMP_W'(span_bytes);
    assign slot_over = CMP_W'(div_quot) >= CMP_W'(slot_limit);

    always_comb begin
        n         = q;
        div_start = 1'b0;
        div_a     = '0;
        div_b     = '0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    n.tvalid    = cfg_valid;
                    n.two_level = cfg_two_level;
                    n.pcode     = cfg_page_code;
                    n.pcount    = cfg_page_count;
                    n.esz_m1    = cfg_entry_m1;
                    n.base      = cfg_base;
                    n.index     = req_index;
                    n.state     = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (!q.tvalid) begin
                    n.code     = RSP_INVALID;
                    n.rsp_addr = '0;
                    n.state    = ST_RESP;
                end else if (!q.two_level) begin
                    if (flat_over) begin
                        n.code     = RSP_RANGE;
                        n.rsp_addr = '0;
                    end else begin
                        n.code     = RSP_OK;
                        n.rsp_addr = q.base + PA_W'(flat_off);
                    end
                    n.state = ST_RESP;
                end else begin
                    div_start = 1'b1;
                    div_a     = DIV_W'(page_bytes);
                    div_b     = DIV_W'(entry_bytes);
                    n.state   = ST_DIV_EPP;
                end
            end
            ST_DIV_EPP: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_a     = DIV_W'(q.index);
                    div_b     = div_quot;
                    n.state   = ST_DIV_SLOT;
                end
            end
            ST_DIV_SLOT: begin
                if (div_done) begin
                    n.rem = div_rem;
                    if (slot_over) begin
                        n.code     = RSP_RANGE;
                        n.rsp_addr = '0;
                        n.state    = ST_RESP;
                    end else begin
                        n.rd_addr = q.base + (PA_W'(div_quot) << 3);
                        n.state   = ST_L1_REQ;
                    end
                end
            end
            ST_L1_REQ: begin
                if (rd_ready) n.state = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (rd_data_valid) begin
                    if (desc_mapped) begin
                        n.code     = RSP_OK;
                        n.rsp_addr = desc_page + PA_W'(page_off);
                    end else begin
                        n.code     = RSP_UNMAPPED;
                        n.rsp_addr = '0;
                    end
                    n.state = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) n.state = ST_IDLE;
            end
            default: n.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.code  <= RSP_OK;
        end else begin
            q <= n;
        end
    end

    assign req_ready  = (q.state == ST_IDLE);
    assign rd_valid   = (q.state == ST_L1_REQ);
    assign rd_addr    = q.rd_addr;
    assign rsp_valid  = (q.state == ST_RESP);
    assign rsp_status = q.code;
    assign rsp_addr   = q.rsp_addr;

endmodule

// File: rtl/tbl_addr_gen_chk.sv
module tbl_addr_gen_chk #(
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [PA_W-1:0] rd_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [1:0]      rsp_status,
    input logic [PA_W-1:0] rsp_addr
);
    // R9: an accepted request closes the request port on the next cycle
    assert_accept_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: a pending response or read means no new request is taken
    assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || rd_valid) |-> !req_ready);

    // R9: the read and the response are never presented together
    assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rsp_valid));

    // R10: a stalled response holds its contents
    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_status)));

    // R10: a stalled read holds its address
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R3, R6, R8: any fault status carries a zero address
    assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_addr == '0));

endmodule

bind tbl_addr_gen tbl_addr_gen_chk #(.PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_status (rsp_status),
    .rsp_addr   (rsp_addr)
);

// File: tb/tbl_addr_gen_tb.sv
module tbl_addr_gen_tb;
    localparam int PA_W  = 48;
    localparam int IDX_W = 20;
    localparam logic [47:0] BASE = 48'h0000_8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic             req_valid = 0, req_ready;
    logic [IDX_W-1:0] req_index = '0;
    logic             cfg_valid = 0, cfg_two_level = 0;
    logic [1:0]       cfg_page_code = 0;
    logic [7:0]       cfg_page_count = 0;
    logic [4:0]       cfg_entry_m1 = 0;
    logic [PA_W-1:0]  cfg_base = BASE;
    logic             rd_valid, rd_ready = 1;
    logic [PA_W-1:0]  rd_addr;
    logic             rd_data_valid = 0;
    logic [63:0]      rd_data = '0;
    logic             rsp_valid, rsp_ready = 0;
    logic [1:0]       rsp_status;
    logic [PA_W-1:0]  rsp_addr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    tbl_addr_gen #(.PA_W(PA_W), .IDX_W(IDX_W)) u_dut (.*);

    typedef struct packed {
        logic        cv;
        logic        tl;
        logic [1:0]  pc;
        logic [7:0]  sz;
        logic [4:0]  em;
        logic [19:0] idx;
        logic [63:0] l1;
        logic        rd_exp;
        logic [47:0] rd_a;
        logic [1:0]  st;
        logic [47:0] ea;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R1 flat, 8-byte entries
        '{1'b1,1'b0,2'd0,8'd0,5'd7,20'd5,64'h0,1'b0,48'h0,2'd0,48'h0000_8000_0028,8'd1},
        // R3 offset equals span
        '{1'b1,1'b0,2'd0,8'd0,5'd7,20'd512,64'h0,1'b0,48'h0,2'd2,48'h0,8'd3},
        // R3 last entry inside span
        '{1'b1,1'b0,2'd0,8'd0,5'd7,20'd511,64'h0,1'b0,48'h0,2'd0,48'h0000_8000_0FF8,8'd3},
        // R2 16 KB pages, two pages, 3-byte entries
        '{1'b1,1'b0,2'd1,8'd1,5'd2,20'd10000,64'h0,1'b0,48'h0,2'd0,48'h0000_8000_7530,8'd2},
        // R2 code 3 acts as 64 KB
        '{1'b1,1'b0,2'd3,8'd0,5'd0,20'd40000,64'h0,1'b0,48'h0,2'd0,48'h0000_8000_9C40,8'd2},
        // R4 R5 two-level, slot 1 remainder 488
        '{1'b1,1'b1,2'd0,8'd0,5'd7,20'd1000,64'h8000_0000_1234_5000,1'b1,48'h0000_8000_0008,2'd0,48'h0000_1234_5F40,8'd5},
        // R6 pointer bit 63 clear
        '{1'b1,1'b1,2'd0,8'd0,5'd7,20'd1000,64'h0000_0000_1234_5000,1'b1,48'h0000_8000_0008,2'd3,48'h0,8'd6},
        // R7 slot 512 of 512
        '{1'b1,1'b1,2'd0,8'd0,5'd2,20'd700000,64'h0,1'b0,48'h0,2'd2,48'h0,8'd7},
        // R7 last slot 511, remainder 1364
        '{1'b1,1'b1,2'd0,8'd0,5'd2,20'd698879,64'h8000_0000_0020_0000,1'b1,48'h0000_8000_0FF8,2'd0,48'h0000_0020_0FFC,8'd7},
        // R5 64 KB page, offset bits of pointer cleared
        '{1'b1,1'b1,2'd2,8'd0,5'd31,20'd2049,64'h8000_0000_ABCD_0123,1'b1,48'h0000_8000_0008,2'd0,48'h0000_ABCD_0020,8'd5},
        // R4 16 KB pages, 4 pages, 5-byte entries: slot 30
        '{1'b1,1'b1,2'd1,8'd3,5'd4,20'd100000,64'h8000_0000_0070_0000,1'b1,48'h0000_8000_00F0,2'd0,48'h0000_0070_2198,8'd4},
        // R8 flat, not allocated
        '{1'b0,1'b0,2'd0,8'd0,5'd7,20'd0,64'h0,1'b0,48'h0,2'd1,48'h0,8'd8},
        // R8 two-level, not allocated
        '{1'b0,1'b1,2'd0,8'd0,5'd7,20'd1000,64'h8000_0000_1234_5000,1'b0,48'h0,2'd1,48'h0,8'd8}
    };

    task automatic report_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            report_end();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [19:0] idx);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 idle ready", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_index = idx;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_cfg(input vec_t v);
        cfg_valid      = v.cv;
        cfg_two_level  = v.tl;
        cfg_page_code  = v.pc;
        cfg_page_count = v.sz;
        cfg_entry_m1   = v.em;
        cfg_base       = BASE;
    endtask

    task automatic run_vec(input vec_t v);
        bit saw_rd = 0;
        set_cfg(v);
        issue(v.idx);
        forever begin
            if (rd_valid) begin
                saw_rd = 1;
                chk(rd_addr == v.rd_a, $sformatf("R%0d read address", v.tag), 64'(rd_addr), 64'(v.rd_a));
                @(negedge clk);
                rd_data_valid = 1'b1;
                rd_data = v.l1;
                @(negedge clk);
                rd_data_valid = 1'b0;
            end else if (rsp_valid) begin
                chk(rsp_status == v.st, $sformatf("R%0d status", v.tag), 64'(rsp_status), 64'(v.st));
                chk(rsp_addr == v.ea, $sformatf("R%0d address", v.tag), 64'(rsp_addr), 64'(v.ea));
                rsp_ready = 1'b1;
                @(negedge clk);
                rsp_ready = 1'b0;
                break;
            end else begin
                @(negedge clk);
            end
        end
        chk(saw_rd == v.rd_exp, $sformatf("R%0d read issued", v.tag), 64'(saw_rd), 64'(v.rd_exp));
    endtask

    initial begin
        logic [47:0] held;
        // R12 reset state
        repeat (3) @(negedge clk);
        chk(req_ready && !rd_valid && !rsp_valid, "R12 in reset", {61'd0, req_ready, rd_valid, rsp_valid}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rd_valid && !rsp_valid, "R12 after reset", {61'd0, req_ready, rd_valid, rsp_valid}, 64'd4);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R11: inputs changed right after acceptance do not matter
        set_cfg(VECS[0]);
        issue(20'd5);
        cfg_entry_m1 = 5'd0;
        cfg_base     = 48'h0;
        cfg_valid    = 1'b0;
        req_index    = 20'd9;
        while (!rsp_valid) @(negedge clk);
        chk(rsp_status == 2'd0, "R11 status", 64'(rsp_status), 64'd0);
        chk(rsp_addr == 48'h0000_8000_0028, "R11 address", 64'(rsp_addr), 64'h0000_8000_0028);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;

        // R9, R10: read back-pressure, busy ready, response back-pressure
        set_cfg(VECS[5]);
        rd_ready = 1'b0;
        issue(20'd1000);
        chk(req_ready == 1'b0, "R9 busy after accept", 64'(req_ready), 64'd0);
        while (!rd_valid) @(negedge clk);
        held = rd_addr;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(rd_valid && rd_addr == held, "R10 read held", 64'(rd_addr), 64'(held));
        end
        rd_ready = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10 read taken", 64'(rd_valid), 64'd0);
        rd_data_valid = 1'b1;
        rd_data = 64'h8000_0000_1234_5000;
        @(negedge clk);
        rd_data_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R9 response after data", 64'(rsp_valid), 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(rsp_valid && !req_ready && rsp_addr == 48'h0000_1234_5F40,
                "R10 response held", 64'(rsp_addr), 64'h0000_1234_5F40);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, "R9 ready after response", 64'(req_ready), 64'd1);

        report_end();
    end

endmodule